// File: doc/BRIEF.md
# Four-Channel Compare Alarm Unit

This block watches the low word of a free-running timebase, which it receives as an input, and raises an interrupt when that word reaches a value that software has programmed. It has four independent channels. Software loads a channel's 32-bit target through an APB-style register port, and that write alone arms the channel. While a channel is armed, the block compares its target with the timebase on every clock. On equality the channel disarms itself and latches a raw interrupt flag.

Software can cancel a pending alarm by writing ones to the armed-status register. Each raw flag is cleared by writing one to it. A per-channel enable mask and a per-channel force mask combine with the raw flags to form a masked status word. Each bit of that status word drives one interrupt line. An external write-inhibit input stops every register write while it is high, which lets a surrounding lock freeze the block's configuration.

Top module: `cmp_alarm_unit`

## Requirements
- R1: After reset, every register reads 0 and every interrupt line is low: the four targets, armed, raw, enable, force and status.
- R2: A write to target offset 0x10 + 4*i stores the data as channel i's target. The same write sets bit i of the armed register at offset 0x20 on the clock edge that completes the write. The target reads back at its offset.
- R3: When channel i is armed and its target equals `time_lo` at a clock edge, that edge clears armed bit i and sets bit i of the raw register at offset 0x3C. A channel that is not armed never sets its raw bit.
- R4: Writing 1 to bit i of the armed register (offset 0x20) disarms channel i without raising its raw bit. Bits written as 0 leave their channels unchanged.
- R5: Writing 1 to bit i of the raw register (offset 0x3C) clears raw bit i. Zero bits have no effect.
- R6: The enable register (offset 0x40) and the force register (offset 0x44) are read/write in bits 3:0, one bit per channel.
- R7: The status register (offset 0x48) reads (raw AND enable) OR force for each channel. `irq_o[i]` equals status bit i at all times.
- R8: If a target write to channel i and a match on channel i fall on the same edge, the write takes effect. The channel holds the new target, stays armed, and its raw bit is not set.
- R9: If a disarm write to channel i and a match on channel i fall on the same edge, the channel ends disarmed and its raw bit is not set.
- R10: While `wr_inhibit` is high, writes to the target, armed, raw, enable and force registers change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| time_lo | input | 32 | Low word of the running timebase |
| wr_inhibit | input | 1 | High blocks all register writes |
| irq_o | output | 4 | One interrupt line per channel (status bits) |

## Verification
A channel can receive a software write in the same cycle that its compare matches. The write can be a new target or a disarm. The bench provokes both cases by changing `time_lo` to the armed target on the same falling edge that raises `penable` for the write, so the match and the write land on the same rising edge. It then reads back armed, raw and the target. A correct design shows the new target still armed, or the channel disarmed, and in both cases no raw flag.

// File: rtl/cmp_alarm_pkg.sv
package cmp_alarm_pkg;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned REG_STRIDE = 4;

    localparam logic [ADDR_W-1:0] OFS_TGT0  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ARMED = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_EN    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FRC   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_STS   = 8'h48;

    // byte offset of channel i's target register
    function automatic logic [ADDR_W-1:0] tgt_ofs(input int unsigned i);
        return OFS_TGT0 + ADDR_W'(i * REG_STRIDE);
    endfunction
endpackage

// File: rtl/alarm_chan.sv
module alarm_chan #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] time_lo,
    input  logic          tgt_we,
    input  logic [DW-1:0] tgt_wdata,
    input  logic          disarm,
    input  logic          raw_clr,
    output logic [DW-1:0] target_o,
    output logic          armed_o,
    output logic          raw_o
);
    typedef struct packed {
        logic [DW-1:0] target;
        logic          armed;
        logic          raw;
    } chan_t;

    chan_t s_d, s_q;
    logic  hit_d;

    always_comb begin
        s_d   = s_q;
        hit_d = 1'b0;
        // software actions take priority over a coincident compare
        if (tgt_we) begin
            s_d.target = tgt_wdata;
            s_d.armed  = 1'b1;
        end else if (disarm) begin
            s_d.armed = 1'b0;
        end else if (s_q.armed && (s_q.target == time_lo)) begin
            s_d.armed = 1'b0;
            hit_d     = 1'b1;
        end
        s_d.raw = (s_q.raw & ~raw_clr) | hit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign target_o = s_q.target;
    assign armed_o  = s_q.armed;
    assign raw_o    = s_q.raw;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we,
    input  logic           frc_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] frc_o,
    output logic [NCH-1:0] sts_o,
    output logic [NCH-1:0] irq_o
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] frc;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (en_we)  m_d.en  = wbits;
        if (frc_we) m_d.frc = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign en_o  = m_q.en;
    assign frc_o = m_q.frc;
    assign sts_o = (raw & m_q.en) | m_q.frc;
    assign irq_o = sts_o;
endmodule

// File: rtl/reg_decode.sv
module reg_decode
    import cmp_alarm_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              wr_inhibit,
    input  logic [NCH*DW-1:0] tgt_flat,
    input  logic [NCH-1:0]    armed,
    input  logic [NCH-1:0]    raw,
    input  logic [NCH-1:0]    en,
    input  logic [NCH-1:0]    frc,
    input  logic [NCH-1:0]    sts,
    input  logic [NCH-1:0]    wbits,
    output logic [NCH-1:0]    tgt_we,
    output logic [NCH-1:0]    disarm,
    output logic [NCH-1:0]    raw_clr,
    output logic              en_we,
    output logic              frc_we,
    output logic [DW-1:0]     prdata
);
    localparam int unsigned PAD = DW - NCH;

    logic wr_ok, rd_ok;

    assign wr_ok = psel && penable && pwrite && !wr_inhibit;
    assign rd_ok = psel && !pwrite;

    for (genvar i = 0; i < NCH; i++) begin : g_we
        assign tgt_we[i] = wr_ok && (paddr == tgt_ofs(i));
    end

    assign disarm  = (wr_ok && paddr == OFS_ARMED) ? wbits : '0;
    assign raw_clr = (wr_ok && paddr == OFS_RAW)   ? wbits : '0;
    assign en_we   = wr_ok && (paddr == OFS_EN);
    assign frc_we  = wr_ok && (paddr == OFS_FRC);

    always_comb begin
        prdata = '0;
        if (rd_ok) begin
            for (int i = 0; i < NCH; i++) begin
                if (paddr == tgt_ofs(i)) prdata = tgt_flat[i*DW +: DW];
            end
            case (paddr)
                OFS_ARMED: prdata = {{PAD{1'b0}}, armed};
                OFS_RAW:   prdata = {{PAD{1'b0}}, raw};
                OFS_EN:    prdata = {{PAD{1'b0}}, en};
                OFS_FRC:   prdata = {{PAD{1'b0}}, frc};
                OFS_STS:   prdata = {{PAD{1'b0}}, sts};
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cmp_alarm_unit.sv
module cmp_alarm_unit
    import cmp_alarm_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    input  logic [DW-1:0]     time_lo,
    input  logic              wr_inhibit,
    output logic [NCH-1:0]    irq_o
);
    logic [NCH*DW-1:0] tgt_flat;
    logic [NCH-1:0]    armed_w, raw_w, en_w, frc_w, sts_w;
    logic [NCH-1:0]    tgt_we, disarm, raw_clr;
    logic              en_we, frc_we;

    reg_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .wr_inhibit(wr_inhibit),
        .tgt_flat  (tgt_flat),
        .armed     (armed_w),
        .raw       (raw_w),
        .en        (en_w),
        .frc       (frc_w),
        .sts       (sts_w),
        .wbits     (pwdata[NCH-1:0]),
        .tgt_we    (tgt_we),
        .disarm    (disarm),
        .raw_clr   (raw_clr),
        .en_we     (en_we),
        .frc_we    (frc_we),
        .prdata    (prdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        alarm_chan #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .time_lo  (time_lo),
            .tgt_we   (tgt_we[i]),
            .tgt_wdata(pwdata),
            .disarm   (disarm[i]),
            .raw_clr  (raw_clr[i]),
            .target_o (tgt_flat[i*DW +: DW]),
            .armed_o  (armed_w[i]),
            .raw_o    (raw_w[i])
        );
    end

    irq_ctrl #(.NCH(NCH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_we (en_we),
        .frc_we(frc_we),
        .wbits (pwdata[NCH-1:0]),
        .raw   (raw_w),
        .en_o  (en_w),
        .frc_o (frc_w),
        .sts_o (sts_w),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/cmp_alarm_chk.sv
module cmp_alarm_chk
    import cmp_alarm_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DW-1:0]     pwdata,
    input logic [DW-1:0]     time_lo,
    input logic              wr_inhibit,
    input logic [NCH*DW-1:0] tgt_flat,
    input logic [NCH-1:0]    armed,
    input logic [NCH-1:0]    raw,
    input logic [NCH-1:0]    en,
    input logic [NCH-1:0]    frc
);
    logic wr_ok;
    assign wr_ok = psel && penable && pwrite && !wr_inhibit;

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R2: a target write arms the channel and stores the data
        a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ok && paddr == tgt_ofs(i)) |=>
            (armed[i] && tgt_flat[i*DW +: DW] == $past(pwdata)));

        // R3: an undisturbed match fires and disarms
        a_r3_fire: assert property (@(posedge clk) disable iff (!rst_n)
            (armed[i] && time_lo == tgt_flat[i*DW +: DW] &&
             !(wr_ok && (paddr == tgt_ofs(i) || (paddr == OFS_ARMED && pwdata[i]))))
            |=> (!armed[i] && raw[i]));

        // R3: a raw flag only rises out of an armed channel
        a_r3_raw_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw[i]) |-> $past(armed[i]));

        // R4 / R9: a disarm write leaves the channel disarmed and quiet
        a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ok && paddr == OFS_ARMED && pwdata[i] && !raw[i]) |=>
            (!armed[i] && !raw[i]));
    end

    // R10: inhibited writes never change the masks
    a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |=> ($stable(en) && $stable(frc)));
endmodule

bind cmp_alarm_unit cmp_alarm_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .time_lo   (time_lo),
    .wr_inhibit(wr_inhibit),
    .tgt_flat  (tgt_flat),
    .armed     (armed_w),
    .raw       (raw_w),
    .en        (en_w),
    .frc       (frc_w)
);

// File: tb/tb_cmp_alarm_unit.sv
module tb_cmp_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] tb_time = 32'h0;
    logic        wr_inhibit = 1'b0;
    logic [3:0]  irq_o;

    int n_cmp = 0;
    int n_mis = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_T0 = 8'h10, A_T1 = 8'h14, A_T2 = 8'h18, A_T3 = 8'h1C;
    localparam logic [7:0] A_ARM = 8'h20, A_RAW = 8'h3C, A_EN = 8'h40;
    localparam logic [7:0] A_FRC = 8'h44, A_STS = 8'h48;

    always #10 clk = ~clk;

    cmp_alarm_unit dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .time_lo(tb_time), .wr_inhibit(wr_inhibit), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write completes on the rising edge before the task returns
    task automatic wr_t(input logic [7:0] a, input logic [31:0] d, input bit tchg, input logic [31:0] t);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        if (tchg) tb_time = t;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_t(a, d, 1'b0, 32'h0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check(req, prdata, exp);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic set_time(input logic [31:0] t);
        @(negedge clk);
        tb_time = t;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 tgt0", A_T0, 0); rd_chk("R1 tgt1", A_T1, 0);
        rd_chk("R1 tgt2", A_T2, 0); rd_chk("R1 tgt3", A_T3, 0);
        rd_chk("R1 armed", A_ARM, 0); rd_chk("R1 raw", A_RAW, 0);
        rd_chk("R1 en", A_EN, 0); rd_chk("R1 frc", A_FRC, 0);
        rd_chk("R1 sts", A_STS, 0);
        check("R1 irq", {28'h0, irq_o}, 0);
    endtask

    task automatic t_arm;
        set_time(32'h1000);
        wr(A_T0, 32'h2000);
        wr(A_T2, 32'h3000);
        rd_chk("R2 armed", A_ARM, 32'h5);
        rd_chk("R2 tgt0", A_T0, 32'h2000);
        rd_chk("R2 tgt2", A_T2, 32'h3000);
    endtask

    task automatic t_fire;
        set_time(32'h2000);
        rd_chk("R3 raw after match", A_RAW, 32'h1);
        rd_chk("R3 armed after match", A_ARM, 32'h4);
    endtask

    task automatic t_raw_clear;
        wr(A_RAW, 32'h0);
        rd_chk("R5 zero write keeps raw", A_RAW, 32'h1);
        wr(A_RAW, 32'h1);
        rd_chk("R5 raw cleared", A_RAW, 32'h0);
        // time still equals target 0, but the channel is disarmed
        rd_chk("R3 disarmed no refire", A_RAW, 32'h0);
    endtask

    task automatic t_disarm;
        wr(A_T1, 32'h4000);
        rd_chk("R2 ch1 armed", A_ARM, 32'h6);
        wr(A_ARM, 32'h2);
        rd_chk("R4 ch1 disarmed only", A_ARM, 32'h4);
        set_time(32'h4000);
        rd_chk("R4 no fire after cancel", A_RAW, 32'h0);
    endtask

    task automatic t_irq;
        set_time(32'h3000);
        rd_chk("R3 ch2 fire", A_RAW, 32'h4);
        check("R7 irq masked", {28'h0, irq_o}, 0);
        wr(A_EN, 32'h4);
        rd_chk("R6 en readback", A_EN, 32'h4);
        rd_chk("R7 sts raw&en", A_STS, 32'h4);
        check("R7 irq en", {28'h0, irq_o}, 32'h4);
        wr(A_EN, 32'h0);
        wr(A_FRC, 32'h9);
        rd_chk("R6 frc readback", A_FRC, 32'h9);
        rd_chk("R7 sts force", A_STS, 32'h9);
        check("R7 irq force", {28'h0, irq_o}, 32'h9);
        wr(A_EN, 32'h4);
        rd_chk("R7 sts combined", A_STS, 32'hD);
        wr(A_FRC, 32'h0);
        wr(A_EN, 32'h0);
        wr(A_RAW, 32'h4);
        check("R7 irq idle", {28'h0, irq_o}, 0);
    endtask

    task automatic t_wr_vs_match;
        set_time(32'h5000);
        wr(A_T3, 32'h6000);
        wr_t(A_T3, 32'h7000, 1'b1, 32'h6000);
        rd_chk("R8 still armed", A_ARM, 32'h8);
        rd_chk("R8 new target", A_T3, 32'h7000);
        rd_chk("R8 no raw", A_RAW, 32'h0);
    endtask

    task automatic t_disarm_vs_match;
        wr_t(A_ARM, 32'h8, 1'b1, 32'h7000);
        rd_chk("R9 disarmed", A_ARM, 32'h0);
        rd_chk("R9 no raw", A_RAW, 32'h0);
    endtask

    task automatic t_inhibit;
        wr(A_T0, 32'h8000);
        set_time(32'h8000);
        wr(A_T1, 32'h9000);
        rd_chk("R3 setup raw", A_RAW, 32'h1);
        @(negedge clk);
        wr_inhibit = 1'b1;
        wr(A_T2, 32'h1234);
        wr(A_ARM, 32'h2);
        wr(A_RAW, 32'h1);
        wr(A_EN, 32'hF);
        wr(A_FRC, 32'hF);
        @(negedge clk);
        wr_inhibit = 1'b0;
        rd_chk("R10 tgt2 kept", A_T2, 32'h3000);
        rd_chk("R10 armed kept", A_ARM, 32'h2);
        rd_chk("R10 raw kept", A_RAW, 32'h1);
        rd_chk("R10 en kept", A_EN, 32'h0);
        rd_chk("R10 frc kept", A_FRC, 32'h0);
        check("R10 irq low", {28'h0, irq_o}, 0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arm();
        t_fire();
        t_raw_clear();
        t_disarm();
        t_irq();
        t_wr_vs_match();
        t_disarm_vs_match();
        t_inhibit();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end
endmodule